// File: doc/BRIEF.md
# Zero-Terminated 8-bit Sample Output Register

This block holds one 8-bit audio sample and presents it to a downstream converter. It can be loaded in two ways, chosen by a mode bit in its control register. In direct mode, software stores each sample into a data register. In capture mode, the block watches CPU read cycles that fall in a program-space window and takes each byte read there as the next sample. A loop of plain reads can then stream samples out of ROM with no store instructions.

A sample of zero is never shown on the output. It marks the end of a stream: the output keeps its previous value and an interrupt flag is raised. The flag can be enabled and read back through the control register, and reading it clears it. The interrupt output is the flag gated by the enable.

The bus is presented as one strobe per CPU cycle. The strobe is high for exactly one clock, at the end of the bus cycle, when address, direction and data are all valid. The bus data input carries write data on writes and the data returned by memory on reads.

Top module: `pcm_dac`

## Requirements
- R1: After reset, `dac_out` is 0x00, `irq_out` is low, the block is in direct mode and the enable is clear, so a control read returns 0x00.
- R2: A write to the control address (default 0x5010) sets the mode from data bit 0 (0 = direct, 1 = capture) and the enable from data bit 7. `irq_out` always equals the flag ANDed with the enable, so a change of enable appears on `irq_out` on the clock after the write.
- R3: During a read of the control address, `rd_data` is {flag AND enable, 7'b0}. It is 0x00 for a read of any other address and for any write.
- R4: A read of the control address clears the interrupt flag.
- R5: In direct mode, a write of a nonzero byte to the sample address (default 0x5011) loads `dac_out` with that byte on the next clock and clears the flag.
- R6: In capture mode, writes to the sample address leave `dac_out` and the flag unchanged.
- R7: In capture mode, a read of any address in the window (default 0x8000 to 0xBFFF, bounds inclusive) takes the bus data as the sample. Reads outside the window are not sampled.
- R8: A sample value of 0x00 leaves `dac_out` unchanged and sets the flag.
- R9: In direct mode, reads in the window do not change `dac_out` or the flag.
- R10: Bus inputs have no effect on any state while `bus_strobe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_strobe | input | 1 | One-clock pulse marking the end of a CPU bus cycle |
| bus_rw | input | 1 | 1 = read cycle, 0 = write cycle |
| bus_addr | input | ADDR_W | CPU address |
| bus_din | input | 8 | Bus data: write data, or the byte memory returns on a read |
| rd_data | output | 8 | Control register read value |
| dac_out | output | 8 | Current sample |
| irq_out | output | 1 | Interrupt request, active high |

## Verification
The bench builds the block with its default parameters: a 16-bit address, the control and sample registers at 0x5010 and 0x5011, and the window from 0x8000 to 0xBFFF. With these values, every one of the 256 sample bytes is fed through both the direct path and the capture path. Window reads are also swept across the full address space, including the addresses on each side of both window bounds. This exercises zero handling, the mode gating and the window compare against an arithmetic model that runs next to the block.

// File: rtl/pcm_dac.sv
module pcm_dac #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h5010,
  parameter logic [ADDR_W-1:0] SMPL_ADDR = 16'h5011,
  parameter logic [ADDR_W-1:0] WIN_LO    = 16'h8000,
  parameter logic [ADDR_W-1:0] WIN_HI    = 16'hBFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_strobe,
  input  logic              bus_rw,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_din,
  output logic [7:0]        rd_data,
  output logic [7:0]        dac_out,
  output logic              irq_out
);
  logic capture_mode, irq_en, flag;

  wire hit_ctrl = bus_addr == CTRL_ADDR;
  wire hit_smpl = bus_addr == SMPL_ADDR;
  wire hit_win  = (bus_addr >= WIN_LO) && (bus_addr <= WIN_HI);

  wire ctrl_wr  = bus_strobe && !bus_rw && hit_ctrl;
  wire ctrl_rd  = bus_strobe &&  bus_rw && hit_ctrl;
  wire smpl_new = bus_strobe && ((!bus_rw && hit_smpl && !capture_mode) ||
                                 ( bus_rw && hit_win  &&  capture_mode));
  wire is_end   = bus_din == 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      capture_mode <= 1'b0;
      irq_en       <= 1'b0;
    end else if (ctrl_wr) begin
      capture_mode <= bus_din[0];
      irq_en       <= bus_din[7];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_out <= 8'h00;
      flag    <= 1'b0;
    end else if (smpl_new) begin
      flag <= is_end;
      if (!is_end) dac_out <= bus_din;
    end else if (ctrl_rd) begin
      flag <= 1'b0;
    end
  end

  assign irq_out = flag && irq_en;
  assign rd_data = (bus_rw && hit_ctrl) ? {irq_out, 7'b0} : 8'h00;
endmodule

// File: rtl/pcm_dac_checker.sv
module pcm_dac_checker #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h5010,
  parameter logic [ADDR_W-1:0] SMPL_ADDR = 16'h5011
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_strobe,
  input logic              bus_rw,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_din,
  input logic [7:0]        dac_out,
  input logic              irq_out,
  input logic              irq_en,
  input logic              capture_mode
);
  assert_irq_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq_out);

  assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe && bus_rw && bus_addr == CTRL_ADDR) |=> !irq_out);

  assert_direct_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe && !bus_rw && bus_addr == SMPL_ADDR && !capture_mode && bus_din != 8'h00)
      |=> (dac_out == $past(bus_din)));

  assert_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe && !bus_rw && bus_addr == SMPL_ADDR && capture_mode) |=> $stable(dac_out));

  assert_end_marker_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe && bus_din == 8'h00) |=> $stable(dac_out));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_strobe |=> ($stable(dac_out) && $stable(irq_en) && $stable(capture_mode)));
endmodule

bind pcm_dac pcm_dac_checker #(
  .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .SMPL_ADDR(SMPL_ADDR)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_strobe(bus_strobe), .bus_rw(bus_rw),
  .bus_addr(bus_addr), .bus_din(bus_din), .dac_out(dac_out), .irq_out(irq_out),
  .irq_en(irq_en), .capture_mode(capture_mode)
);

// File: tb/pcm_dac_tb_top.sv
module pcm_dac_tb_top;
  localparam logic [15:0] CTRL = 16'h5010, SMPL = 16'h5011;
  localparam logic [15:0] WLO = 16'h8000, WHI = 16'hBFFF;

  logic clk = 0, rst_n = 0;
  logic bus_strobe = 0, bus_rw = 0;
  logic [15:0] bus_addr = 0;
  logic [7:0] bus_din = 0;
  logic [7:0] rd_data, dac_out;
  logic irq_out;

  int vectors = 0, errors = 0;
  logic [7:0] m_dac = 0;
  logic m_flag = 0, m_en = 0, m_mode = 0;

  always #4 clk = ~clk;

  pcm_dac dut_i (.clk(clk), .rst_n(rst_n), .bus_strobe(bus_strobe), .bus_rw(bus_rw),
    .bus_addr(bus_addr), .bus_din(bus_din), .rd_data(rd_data), .dac_out(dac_out),
    .irq_out(irq_out));

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic state_chk(input string req);
    chk(req, {1'b0, dac_out}, {1'b0, m_dac});
    chk(req, {8'b0, irq_out}, {8'b0, m_flag & m_en});
  endtask

  task automatic bus_op(input logic rw, input logic [15:0] a, input logic [7:0] d,
                        input logic strobe, output logic [7:0] rd);
    @(negedge clk);
    bus_rw = rw; bus_addr = a; bus_din = d; bus_strobe = strobe;
    #1 rd = rd_data;
    @(negedge clk);
    bus_strobe = 0;
    if (strobe) begin
      if (!rw && a == CTRL) begin m_mode = d[0]; m_en = d[7]; end
      if (rw && a == CTRL) m_flag = 0;
      if ((!rw && a == SMPL && !m_mode) || (rw && m_mode && a >= WLO && a <= WHI)) begin
        if (d == 8'h00) m_flag = 1;
        else begin m_dac = d; m_flag = 0; end
      end
    end
  endtask

  logic [7:0] rv;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    state_chk("R1");
    bus_op(1, CTRL, 8'h00, 1, rv);
    chk("R1", {1'b0, rv}, 9'h000);

    // R2 enable on, direct mode; R5/R8 sweep all sample values
    bus_op(0, CTRL, 8'h80, 1, rv);
    for (int v = 255; v >= 0; v--) begin
      bus_op(0, SMPL, v[7:0], 1, rv);
      state_chk(v == 0 ? "R8" : "R5");
    end
    // R2 disable masks irq, re-enable restores it
    bus_op(0, CTRL, 8'h00, 1, rv); state_chk("R2");
    bus_op(0, CTRL, 8'h80, 1, rv); state_chk("R2");
    // R3 read value, R4 clear
    bus_op(1, CTRL, 8'h00, 1, rv);
    chk("R3", {1'b0, rv}, 9'h080);
    state_chk("R4");
    bus_op(1, CTRL, 8'h00, 1, rv);
    chk("R4", {1'b0, rv}, 9'h000);
    // R3 other addresses return 0
    bus_op(0, SMPL, 8'h00, 1, rv);
    bus_op(1, SMPL, 8'h00, 1, rv); chk("R3", {1'b0, rv}, 9'h000);
    bus_op(0, CTRL, 8'h80, 1, rv); chk("R3", {1'b0, rv}, 9'h000);
    bus_op(1, CTRL, 8'h00, 1, rv);

    // R9 window reads ignored in direct mode
    for (int a = 0; a < 65536; a += 1024) begin
      bus_op(1, a[15:0], 8'h5A, 1, rv); state_chk("R9");
    end
    bus_op(1, WLO, 8'h00, 1, rv); state_chk("R9");

    // R10 no strobe: nothing changes
    bus_op(0, CTRL, 8'h81, 0, rv); state_chk("R10");
    bus_op(0, SMPL, 8'h33, 0, rv); state_chk("R10");

    // enter capture mode with irq enabled
    bus_op(0, CTRL, 8'h81, 1, rv);
    for (int v = 255; v >= 0; v--) begin
      bus_op(1, WLO + 16'(v * 64), v[7:0], 1, rv);
      state_chk(v == 0 ? "R8" : "R7");
    end
    // R6 sample writes ignored
    for (int v = 1; v < 256; v += 37) begin
      bus_op(0, SMPL, v[7:0], 1, rv); state_chk("R6");
    end
    bus_op(0, SMPL, 8'h00, 1, rv); state_chk("R6");
    // R7 address sweep and window edges
    for (int a = 0; a < 65536; a += 512) begin
      bus_op(1, a[15:0], 8'(a[16:9] | 8'h01), 1, rv); state_chk("R7");
    end
    bus_op(1, 16'h7FFF, 8'h11, 1, rv); state_chk("R7");
    bus_op(1, 16'h8000, 8'h22, 1, rv); state_chk("R7");
    bus_op(1, 16'hBFFF, 8'h33, 1, rv); state_chk("R7");
    bus_op(1, 16'hC000, 8'h44, 1, rv); state_chk("R7");
    bus_op(1, 16'hBFFF, 8'h00, 1, rv); state_chk("R8");
    bus_op(1, 16'hC000, 8'h00, 1, rv); state_chk("R7");
    // R10 no strobe in capture mode
    bus_op(1, 16'h9000, 8'h77, 0, rv); state_chk("R10");
    bus_op(1, CTRL, 8'h00, 1, rv);
    chk("R3", {1'b0, rv}, 9'h080);
    state_chk("R4");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule